// File: doc/BRIEF.md
# Load/Store Bus Master with Wait-Request Stall

This block is the load/store unit of a combined memory and write-back pipeline stage. When a load or store sits in the stage, it registers the request and drives one master transaction onto a shared memory-mapped bus. That bus carries a word address, per-lane byte enables, separate read and write strobes, write data, read data and a wait-request from the slave. The same bus reaches data RAM and the peripheral registers, so one master serves every data access. Address decoding and the slaves themselves sit outside this block.

Stores of bytes and halfwords have their data copied into every lane of the 32-bit little-endian word, and the byte enables pick the lanes that are written. Load data is shifted down from the addressed lane and sign- or zero-extended. The unit raises a stall to the pipeline from the cycle the request arrives until the cycle the slave drops wait-request. An access with no wait states therefore completes one cycle after it is issued. A slower slave stretches the stall for as many cycles as it holds wait-request.

Top module: `lsu_bus_master`

## Requirements
- R1: After reset, with no request, `bus_read`, `bus_write`, `stall` and `acc_done` are all low.
- R2: A request (`mem_valid` high) that arrives while the unit is idle raises `stall` in that same cycle. In the next cycle it drives exactly one strobe: `bus_write` for a store, `bus_read` for a load. `bus_addr` equals `mem_addr` with bits [1:0] cleared.
- R3: While a strobe is high and `bus_waitreq` is high, `bus_addr`, `bus_byteen`, `bus_wdata`, `bus_read` and `bus_write` do not change in the next cycle.
- R4: `stall` stays high in every bus cycle where `bus_waitreq` is high. In the first bus cycle where `bus_waitreq` is low, `stall` is low and `acc_done` is high. An access with N wait cycles therefore completes N+1 cycles after the request cycle.
- R5: The size encoding is 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. The byte enables are 1 << addr[1:0] for a byte. For a halfword they are 4'b0011 when addr[1] = 0 and 4'b1100 when addr[1] = 1. For a word they are 4'b1111.
- R6: On a store, `bus_wdata` holds `mem_wdata[7:0]` in all four lanes for a byte and `mem_wdata[15:0]` in both halves for a halfword. It holds `mem_wdata` unchanged for a word.
- R7: On load completion, `ld_data` holds the addressed byte or halfword, or the whole word, moved down to bit 0. It is sign-extended when `mem_unsigned` is 0 and zero-extended when `mem_unsigned` is 1.
- R8: `bus_read` and `bus_write` are never high together, and neither is high while no access is in progress.
- R9: `acc_done` is high for exactly one cycle per access. `ld_data` is zero in every cycle that does not complete a load.
- R10: A request still held on the inputs during its own completion cycle is not issued a second time. A new request in the following cycle is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid | input | 1 | A memory instruction occupies the stage |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| mem_unsigned | input | 1 | Zero-extend load data when 1 |
| mem_addr | input | 32 | Byte address |
| mem_wdata | input | 32 | Store data, right-aligned |
| stall | output | 1 | Hold the pipeline |
| acc_done | output | 1 | Access completes this cycle |
| ld_data | output | 32 | Formatted load result |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_byteen | output | 4 | Active lanes |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_rdata | input | 32 | Read data from the slave |
| bus_waitreq | input | 1 | Slave is not ready to complete |

## Verification
If the busy state is wrong, it shows at the ports at once. A stuck-busy unit keeps a strobe high with no access, and that strobe appears in the cycle after the previous completion. A lost busy drops the strobe while wait-request is still high, so the slave sees a command that changes or vanishes within one cycle. Errors in the latched command show in the first bus cycle as a wrong address, wrong lanes or unreplicated data. Errors in the load formatting show only in the completion cycle, as a wrong `ld_data` value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int unsigned AW = 32;
  parameter int unsigned DW = 32;
  localparam int unsigned NLANE = DW / 8;
  localparam int unsigned LW = $clog2(NLANE);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic              wr;
    size_e             size;
    logic              uns;
    logic [LW-1:0]     lane;
    logic [AW-1:0]     addr;
    logic [NLANE-1:0]  be;
    logic [DW-1:0]     data;
  } cmd_t;

  function automatic logic [AW-1:0] word_align(logic [AW-1:0] a);
    word_align = {a[AW-1:LW], {LW{1'b0}}};
  endfunction

  function automatic logic [NLANE-1:0] lane_enables(size_e sz, logic [LW-1:0] lane);
    case (sz)
      SZ_BYTE: lane_enables = NLANE'(1) << lane;
      SZ_HALF: lane_enables = NLANE'(3) << {lane[LW-1:1], 1'b0};
      default: lane_enables = '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] place_store(size_e sz, logic [DW-1:0] wd);
    case (sz)
      SZ_BYTE: place_store = {NLANE{wd[7:0]}};
      SZ_HALF: place_store = {(NLANE/2){wd[15:0]}};
      default: place_store = wd;
    endcase
  endfunction

  function automatic logic [DW-1:0] extract_load(size_e sz, logic uns,
                                                 logic [LW-1:0] lane, logic [DW-1:0] rd);
    logic [DW-1:0] s;
    case (sz)
      SZ_BYTE: begin
        s = rd >> {lane, 3'b000};
        extract_load = {{(DW-8){~uns & s[7]}}, s[7:0]};
      end
      SZ_HALF: begin
        s = rd >> {lane[LW-1:1], 1'b0, 3'b000};
        extract_load = {{(DW-16){~uns & s[15]}}, s[15:0]};
      end
      default: begin
        s = rd;
        extract_load = s;
      end
    endcase
  endfunction
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic waitreq,
  output logic accept,
  output logic busy,
  output logic done,
  output logic stall
);
  logic busy_q;

  assign accept = req_valid & ~busy_q;
  assign busy   = busy_q;
  assign done   = busy_q & ~waitreq;
  assign stall  = accept | (busy_q & waitreq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done)   busy_q <= 1'b0;
  end
endmodule

// File: rtl/lsu_cmd_reg.sv
module lsu_cmd_reg
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output cmd_t              cmd,
  output logic [AW-1:0]     bus_addr,
  output logic [NLANE-1:0]  bus_byteen,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_read,
  output logic              bus_write
);
  cmd_t  cmd_q;
  cmd_t  cmd_d;
  size_e sz;

  assign sz = size_e'(req_size);

  always_comb begin
    cmd_d.wr   = req_write;
    cmd_d.size = sz;
    cmd_d.uns  = req_unsigned;
    cmd_d.lane = req_addr[LW-1:0];
    cmd_d.addr = word_align(req_addr);
    cmd_d.be   = lane_enables(sz, req_addr[LW-1:0]);
    cmd_d.data = req_write ? place_store(sz, req_wdata) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_d;
  end

  assign cmd        = cmd_q;
  assign bus_addr   = cmd_q.addr;
  assign bus_byteen = cmd_q.be;
  assign bus_wdata  = cmd_q.data;
  assign bus_read   = busy & ~cmd_q.wr;
  assign bus_write  = busy &  cmd_q.wr;
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  cmd_t          cmd,
  input  logic          done,
  input  logic [DW-1:0] rdata,
  output logic          load_done,
  output logic [DW-1:0] ld_data
);
  assign load_done = done & ~cmd.wr;
  assign ld_data   = load_done ? extract_load(cmd.size, cmd.uns, cmd.lane, rdata) : '0;
endmodule

// File: rtl/lsu_bus_master.sv
module lsu_bus_master
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [1:0]        mem_size,
  input  logic              mem_unsigned,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_wdata,
  output logic              stall,
  output logic              acc_done,
  output logic [DW-1:0]     ld_data,
  output logic [AW-1:0]     bus_addr,
  output logic [NLANE-1:0]  bus_byteen,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_waitreq
);
  logic accept;
  logic busy;
  logic done;
  logic load_done;
  cmd_t cmd;

  lsu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (mem_valid),
    .waitreq   (bus_waitreq),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .stall     (stall)
  );

  lsu_cmd_reg u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .busy         (busy),
    .req_write    (mem_write),
    .req_size     (mem_size),
    .req_unsigned (mem_unsigned),
    .req_addr     (mem_addr),
    .req_wdata    (mem_wdata),
    .cmd          (cmd),
    .bus_addr     (bus_addr),
    .bus_byteen   (bus_byteen),
    .bus_wdata    (bus_wdata),
    .bus_read     (bus_read),
    .bus_write    (bus_write)
  );

  lsu_load_fmt u_fmt (
    .cmd       (cmd),
    .done      (done),
    .rdata     (bus_rdata),
    .load_done (load_done),
    .ld_data   (ld_data)
  );

  assign acc_done = done;
endmodule

// File: rtl/lsu_bus_master_chk.sv
module lsu_bus_master_chk
  import lsu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             stall,
  input logic             acc_done,
  input logic             load_done,
  input logic [DW-1:0]    ld_data,
  input logic [AW-1:0]    bus_addr,
  input logic [NLANE-1:0] bus_byteen,
  input logic             bus_read,
  input logic             bus_write,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_waitreq
);
  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bus_read || bus_write));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_waitreq) |=>
      ($stable(bus_addr) && $stable(bus_byteen) && $stable(bus_wdata) &&
       $stable(bus_read) && $stable(bus_write)));

  p_stall_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_waitreq) |-> stall);

  p_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) |->
      ($countones(bus_byteen) == 1 || $countones(bus_byteen) == 2 ||
       $countones(bus_byteen) == 4));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_read && !bus_write));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  p_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (ld_data == '0));
endmodule

bind lsu_bus_master lsu_bus_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .busy        (busy),
  .stall       (stall),
  .acc_done    (acc_done),
  .load_done   (load_done),
  .ld_data     (ld_data),
  .bus_addr    (bus_addr),
  .bus_byteen  (bus_byteen),
  .bus_read    (bus_read),
  .bus_write   (bus_write),
  .bus_wdata   (bus_wdata),
  .bus_waitreq (bus_waitreq)
);

// File: tb/lsu_bus_master_bench.sv
module lsu_bus_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid = 1'b0;
  logic        mem_write = 1'b0;
  logic [1:0]  mem_size = 2'd0;
  logic        mem_unsigned = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic        stall, acc_done, bus_read, bus_write, bus_waitreq;
  logic [31:0] ld_data, bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_byteen;

  int nchecks = 0;
  int nerr = 0;
  logic [3:0] slave_lat = 4'd0;
  logic [3:0] wcnt;
  logic [31:0] smem [16];
  logic [7:0]  mbytes [64];

  always #5 clk = ~clk;

  lsu_bus_master u_lsu_bus_master (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_size(mem_size), .mem_unsigned(mem_unsigned), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .stall(stall), .acc_done(acc_done), .ld_data(ld_data),
    .bus_addr(bus_addr), .bus_byteen(bus_byteen), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_waitreq(bus_waitreq)
  );

  // behavioural slave: holds wait-request for slave_lat cycles per access
  assign bus_waitreq = (bus_read || bus_write) && (wcnt < slave_lat);
  assign bus_rdata   = smem[bus_addr[5:2]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      for (int i = 0; i < 16; i++) smem[i] <= '0;
    end else begin
      wcnt <= bus_waitreq ? wcnt + 4'd1 : 4'd0;
      if (bus_write && !bus_waitreq)
        for (int i = 0; i < 4; i++)
          if (bus_byteen[i]) smem[bus_addr[5:2]][8*i +: 8] <= bus_wdata[8*i +: 8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input bit wr, input logic [1:0] sz, input bit uns,
                            input logic [31:0] addr, input logic [31:0] wd,
                            input logic [3:0] lat);
    logic [3:0]  ebe;
    logic [31:0] ewd, eld;
    int base;
    int nb;
    nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    base = int'(addr[5:0]) & ~(nb - 1);
    ebe  = 4'((nb == 1) ? 1 : (nb == 2) ? 3 : 15) << (base % 4);
    if (nb == 1)      ewd = {wd[7:0], wd[7:0], wd[7:0], wd[7:0]};
    else if (nb == 2) ewd = {wd[15:0], wd[15:0]};
    else              ewd = wd;
    eld = '0;
    for (int i = nb - 1; i >= 0; i--) eld = (eld << 8) | 32'(mbytes[base + i]);
    if (!uns && nb < 4 && eld[8*nb-1]) eld = eld | (32'hFFFF_FFFF << (8*nb));

    @(negedge clk);
    // R10: whatever is still on the inputs, nothing is issued in this cycle
    check(!bus_read && !bus_write && !acc_done, "R10 no reissue", {30'd0, bus_read, bus_write}, 32'd0);
    slave_lat = lat;
    mem_valid = 1'b1; mem_write = wr; mem_size = sz; mem_unsigned = uns;
    mem_addr = addr; mem_wdata = wd;
    #1;
    check(stall && !bus_read && !bus_write, "R2 stall in request cycle", {31'd0, stall}, 32'd1);
    for (int k = 1; k <= int'(lat) + 1; k++) begin
      @(negedge clk); #1;
      check(bus_write == wr && bus_read == !wr, "R2 strobe", {30'd0, bus_read, bus_write}, {30'd0, !wr, wr});
      check(bus_addr == {addr[31:2], 2'b00}, "R2/R3 address", bus_addr, {addr[31:2], 2'b00});
      check(bus_byteen == ebe, "R5 byte enables", {28'd0, bus_byteen}, {28'd0, ebe});
      if (wr) check(bus_wdata == ewd, "R6 store lanes", bus_wdata, ewd);
      if (k <= int'(lat)) begin
        check(stall && !acc_done, "R4 stall under wait-request", {31'd0, stall}, 32'd1);
      end else begin
        check(!stall && acc_done, "R4 completion", {30'd0, stall, acc_done}, 32'd1);
        if (!wr) check(ld_data == eld, "R7 load data", ld_data, eld);
        else     check(ld_data == 32'd0, "R9 ld_data zero on store", ld_data, 32'd0);
      end
    end
    if (wr)
      for (int i = 0; i < 4; i++)
        if (ebe[i]) mbytes[(base & ~3) + i] = ewd[8*i +: 8];
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    mem_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      check(!bus_read && !bus_write && !stall && !acc_done && ld_data == 0,
            "R8/R9 idle quiet", {28'd0, bus_read, bus_write, stall, acc_done}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!bus_read && !bus_write && !stall && !acc_done, "R1 in reset",
          {28'd0, bus_read, bus_write, stall, acc_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_read && !bus_write && !stall && !acc_done, "R1 after reset",
          {28'd0, bus_read, bus_write, stall, acc_done}, 32'd0);
  endtask

  task automatic t_words;
    run_access(1'b1, 2'd2, 1'b0, 32'h8000_0000, 32'h8BAD_F00D, 4'd0);
    run_access(1'b0, 2'd2, 1'b0, 32'h8000_0000, 32'h0, 4'd0);
    run_access(1'b1, 2'd3, 1'b0, 32'h0000_0013, 32'h1234_5678, 4'd0); // R5 size 3 = word
    run_access(1'b0, 2'd2, 1'b1, 32'h0000_0010, 32'h0, 4'd1);
    go_idle(2);
  endtask

  task automatic t_bytes;
    for (int i = 0; i < 4; i++)
      run_access(1'b1, 2'd0, 1'b0, 32'h0000_0004 + 32'(i), 32'hFFFF_FF00 | 32'(8'h7E + 8'(i)), 4'd1);
    for (int i = 0; i < 4; i++) begin
      run_access(1'b0, 2'd0, 1'b0, 32'h0000_0004 + 32'(i), 32'h0, 4'd0);
      run_access(1'b0, 2'd0, 1'b1, 32'h0000_0004 + 32'(i), 32'h0, 4'd2);
    end
    go_idle(1);
  endtask

  task automatic t_halves;
    run_access(1'b1, 2'd1, 1'b0, 32'h0000_0008, 32'hAAAA_7FFE, 4'd0);
    run_access(1'b1, 2'd1, 1'b0, 32'h0000_000B, 32'h5555_8001, 4'd2);
    run_access(1'b0, 2'd1, 1'b0, 32'h0000_0008, 32'h0, 4'd0);
    run_access(1'b0, 2'd1, 1'b0, 32'h0000_000A, 32'h0, 4'd1);
    run_access(1'b0, 2'd1, 1'b1, 32'h0000_000A, 32'h0, 4'd0);
    run_access(1'b0, 2'd2, 1'b0, 32'h0000_0008, 32'h0, 4'd0);
    go_idle(1);
  endtask

  task automatic t_long_wait;
    run_access(1'b1, 2'd2, 1'b0, 32'h0000_003C, 32'hCAFE_0001, 4'd7);
    run_access(1'b0, 2'd2, 1'b0, 32'h0000_003C, 32'h0, 4'd9);
    run_access(1'b0, 2'd0, 1'b0, 32'h0000_003F, 32'h0, 4'd5);
    go_idle(3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mbytes[i] = 8'h00;
    t_reset();
    t_words();
    t_bytes();
    t_halves();
    t_long_wait();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule